// File: doc/BRIEF.md
# Accumulator Logic and Compare Unit

This block is the logical slice of an 8-bit accumulator machine. It holds the accumulator, six general byte registers and a packed flag byte. On each cycle where the execute strobe is high it carries out one operation: a bitwise AND, OR or XOR of the accumulator with an operand, a compare of the accumulator against an operand, or a move of the operand into a register. The operand comes from the accumulator, one of the general registers, an immediate byte, or the memory byte addressed by the high/low register pair.

The memory address is the register pair concatenated and is driven out at all times. The memory byte is expected back combinationally in the same cycle. The accumulator and the flag byte are presented on output ports after every update. Arithmetic, shifts, rotates and decimal adjust are handled by other slices.

Top module: `logic_cmp_alu`

## Requirements
- R1: After reset, the accumulator, the flag byte and every general register read as zero, so the memory address is 0x0000.
- R2: The flag byte holds zero flag in bit 7, subtract flag in bit 6, half-borrow flag in bit 5 and carry flag in bit 4. Bits 3:0 always read zero.
- R3: Operation code 0 (AND) writes accumulator AND operand into the accumulator. It sets zero when that result is 0, clears subtract and carry, and sets half-borrow to 1.
- R4: Operation codes 1 (XOR) and 2 (OR) write their bitwise result into the accumulator. They set zero when the result is 0 and clear subtract, half-borrow and carry.
- R5: Operation code 3 (compare) leaves the accumulator unchanged. It sets subtract to 1, sets zero when accumulator equals operand, and sets carry when the operand is larger than the accumulator.
- R6: For compare, half-borrow is set exactly when the operand's low nibble is larger than the accumulator's low nibble.
- R7: Source code src_sel[3]=1 selects the immediate byte. Otherwise src_sel[2:0] selects 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at {H,L}, 7=accumulator.
- R8: Operation code 4 (move) writes the operand into the register chosen by dst_sel (same register codes as R7) and leaves the flags unchanged. dst_sel 6 writes nothing.
- R9: With the execute strobe low, no register, accumulator or flag changes, whatever the other inputs are.
- R10: The memory address output always equals {H,L}, high byte from H.
- R11: Operation codes 5 to 7 change neither the registers nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute strobe; one operation per high cycle |
| op | input | 3 | Operation code (AND, XOR, OR, compare, move) |
| src_sel | input | 4 | Operand source select |
| dst_sel | input | 3 | Move destination register |
| imm | input | 8 | Immediate operand byte |
| mem_rdata | input | 8 | Byte read from memory at mem_addr |
| mem_addr | output | 16 | Address formed from the H/L pair |
| acc_out | output | 8 | Current accumulator |
| flags_out | output | 8 | Current packed flag byte |

## Verification
Every result is registered, so a wrong flag or accumulator update shows on acc_out or flags_out one cycle after the strobed operation. A corrupted B to E register stays hidden until it is used as an operand. The bench therefore pulls register contents into the accumulator through moves and logic operations, and a bad value is reported on the first operation that reads it. A wrong H or L value appears on mem_addr right after the write. It also changes the memory byte that later memory-sourced operations read.

// File: rtl/logic_cmp_alu.sv
module logic_cmp_alu #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_en,
  input  logic [2:0]       op,
  input  logic [3:0]       src_sel,
  input  logic [2:0]       dst_sel,
  input  logic [W-1:0]     imm,
  input  logic [W-1:0]     mem_rdata,
  output logic [2*W-1:0]   mem_addr,
  output logic [W-1:0]     acc_out,
  output logic [7:0]       flags_out
);
  localparam int NREG  = 8;
  localparam int IDX_H = 4;
  localparam int IDX_L = 5;
  localparam int IDX_M = 6;
  localparam int IDX_A = 7;
  localparam int NIB   = 4;

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_XOR = 3'd1;
  localparam logic [2:0] OP_OR  = 3'd2;
  localparam logic [2:0] OP_CMP = 3'd3;
  localparam logic [2:0] OP_MOV = 3'd4;

  logic [W-1:0] regs [NREG];
  logic [3:0]   flg_q;

  logic [W-1:0] acc, opnd, logic_res;
  logic [W:0]   diff;
  logic [3:0]   flg_d;
  logic         is_logic;

  assign acc      = regs[IDX_A];
  assign mem_addr = {regs[IDX_H], regs[IDX_L]};
  assign acc_out  = acc;
  assign flags_out = {flg_q, 4'b0000};

  assign opnd = src_sel[3]                  ? imm :
                (src_sel[2:0] == 3'(IDX_M)) ? mem_rdata :
                                              regs[src_sel[2:0]];

  assign diff     = {1'b0, acc} - {1'b0, opnd};
  assign is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);

  always_comb begin
    case (op)
      OP_AND:  logic_res = acc & opnd;
      OP_XOR:  logic_res = acc ^ opnd;
      default: logic_res = acc | opnd;
    endcase
  end

  always_comb begin
    flg_d = flg_q;
    if (is_logic)
      flg_d = {logic_res == '0, 1'b0, op == OP_AND, 1'b0};
    else if (op == OP_CMP)
      flg_d = {diff[W-1:0] == '0, 1'b1, opnd[NIB-1:0] > acc[NIB-1:0], diff[W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      flg_q <= '0;
    end else if (exec_en) begin
      flg_q <= flg_d;
      if (is_logic)
        regs[IDX_A] <= logic_res;
      else if (op == OP_MOV && dst_sel != 3'(IDX_M))
        regs[dst_sel] <= opnd;
    end
  end

  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(acc_out) && $stable(flags_out) && $stable(mem_addr));

  a_r3_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == OP_AND |=> flags_out[6:4] == 3'b010);

  a_r4_orxor_flags: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == OP_OR || op == OP_XOR) |=> flags_out[6:4] == 3'b000);

  a_r3_r4_zero_tracks_acc: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_logic |=> flags_out[7] == (acc_out == '0));

  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == OP_CMP |=> $stable(acc_out) && flags_out[6]);

  a_r8_move_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == OP_MOV |=> $stable(flags_out));

  a_r11_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op > OP_MOV |=> $stable(acc_out) && $stable(flags_out) && $stable(mem_addr));
endmodule

// File: tb/test_logic_cmp_alu.sv
`timescale 1ns/1ps
module test_logic_cmp_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        exec_en = 0;
  logic [2:0]  op = 0;
  logic [3:0]  src_sel = 0;
  logic [2:0]  dst_sel = 0;
  logic [7:0]  imm = 0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  acc_out, flags_out;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m [8];
  logic [3:0] mf;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mem_rdata = memf(mem_addr);

  logic_cmp_alu i_logic_cmp_alu (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .src_sel(src_sel),
    .dst_sel(dst_sel), .imm(imm), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .acc_out(acc_out), .flags_out(flags_out));

  function automatic logic [7:0] opnd_f(input logic [3:0] s, input logic [7:0] im);
    if (s[3]) return im;
    if (s[2:0] == 3'd6) return memf({m[4], m[5]});
    return m[s[2:0]];
  endfunction

  task automatic model(input logic [2:0] o, input logic [3:0] s, input logic [2:0] d,
                       input logic [7:0] im);
    logic [7:0] v, r;
    v = opnd_f(s, im);
    case (o)
      3'd0: begin r = m[7] & v; m[7] = r; mf = {r == 0, 1'b0, 1'b1, 1'b0}; end
      3'd1: begin r = m[7] ^ v; m[7] = r; mf = {r == 0, 1'b0, 1'b0, 1'b0}; end
      3'd2: begin r = m[7] | v; m[7] = r; mf = {r == 0, 1'b0, 1'b0, 1'b0}; end
      3'd3: mf = {m[7] == v, 1'b1, v[3:0] > m[7][3:0], v > m[7]};
      3'd4: if (d != 3'd6) m[d] = v;
      default: ;
    endcase
  endtask

  task automatic check(input string req);
    logic [7:0] ef;
    ef = {mf, 4'b0000};
    n_tests++;
    if (acc_out !== m[7] || flags_out !== ef || mem_addr !== {m[4], m[5]}) begin
      n_fail++;
      $display("FAIL %s: acc=%h flags=%h addr=%h expected acc=%h flags=%h addr=%h",
               req, acc_out, flags_out, mem_addr, m[7], ef, {m[4], m[5]});
    end
  endtask

  task automatic step(input logic en, input logic [2:0] o, input logic [3:0] s,
                      input logic [2:0] d, input logic [7:0] im, input string req);
    @(negedge clk);
    exec_en = en; op = o; src_sel = s; dst_sel = d; imm = im;
    if (en) model(o, s, d, im);
    @(negedge clk);
    exec_en = 0;
    check(req);
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m[i] = 0;
    mf = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");

    step(1, 3'd4, 4'b1000, 3'd7, 8'h3C, "R8 move imm to A");
    step(1, 3'd4, 4'b1000, 3'd0, 8'hA5, "R8 move imm to B");
    step(1, 3'd4, 4'b1000, 3'd4, 8'h12, "R10 move to H");
    step(1, 3'd4, 4'b1000, 3'd5, 8'h34, "R10 move to L");
    step(1, 3'd0, 4'b0000, 3'd0, 8'h00, "R3 AND with B");
    step(1, 3'd0, 4'b1000, 3'd0, 8'hC3, "R3 AND zero result sets Z and H");
    step(1, 3'd4, 4'b1000, 3'd6, 8'hFF, "R8 dst 6 writes nothing");
    step(1, 3'd2, 4'b0110, 3'd0, 8'h00, "R7 OR memory byte");
    step(1, 3'd1, 4'b0111, 3'd0, 8'h00, "R4 XOR A with itself gives Z");
    step(1, 3'd4, 4'b1000, 3'd7, 8'h20, "R8 move imm 20");
    step(1, 3'd3, 4'b1000, 3'd0, 8'h0F, "R6 CMP nibble borrow only");
    step(1, 3'd3, 4'b1000, 3'd0, 8'h20, "R5 CMP equal sets Z");
    step(1, 3'd3, 4'b1000, 3'd0, 8'h30, "R5 CMP borrow sets C");
    step(0, 3'd0, 4'b1000, 3'd7, 8'h00, "R9 no strobe no change");
    step(1, 3'd5, 4'b1000, 3'd7, 8'h99, "R11 reserved op 5");
    step(1, 3'd7, 4'b1000, 3'd7, 8'h99, "R11 reserved op 7");
    step(1, 3'd4, 4'b0000, 3'd7, 8'h00, "R7 move B to A");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] o;
      logic [3:0] s;
      o = 3'($urandom_range(0, 7));
      s = 4'($urandom_range(0, 15));
      step(1'($urandom_range(0, 5) != 0), o, s, 3'($urandom_range(0, 7)),
           8'($urandom_range(0, 255)), "R2 R7 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule